// File: doc/BRIEF.md
# Ethernet Receive Frame Capture Buffer

This block captures one received Ethernet frame at a time. A physical-layer adapter delivers the frame as serial data over a three-wire slave link: an active-low select, a shift clock and a data line. The block synchronises these wires into the system clock domain and packs the bits into bytes, most significant bit first. It writes each completed byte into a 2048-byte buffer, at the address held by a byte counter that starts at zero.

When the select line goes inactive, the frame is complete. The counter then stops and becomes the frame length, and a frame-received flag is raised. A CPU reads the buffer, the length and the flag through a small memory map. After software has consumed the frame, it writes to the status address to make the receiver ready again.

An address filter beside the block can assert a reject input while a frame arrives. The rest of that frame is then dropped without raising the flag, and the receiver stays ready for the next frame. The frame check sequence is left to software.

Top module: `eth_rx_capture`

## Requirements
- R1: After reset, the frame-received flag is 0 and the length reads as 0.
- R2: While select is low, each rising shift clock shifts in one data bit, most significant bit first. Every 8th bit stores one byte at the next buffer offset, starting from offset 0. Bits left over when select rises are not stored.
- R3: When select rises during a capture, the frame-received flag is set. Reading 0xFB00 returns the flag in bit 0 and zeros in bits 7:1.
- R4: The length is the number of stored bytes. The low byte reads at 0xFB02 and the high byte at 0xFB03. Length and buffer hold their values while the flag is set, and any serial traffic in that time is ignored.
- R5: A read in 0xF000–0xF7FF returns the buffer byte at offset address[10:0]. Every read returns its data in the cycle after the read strobe.
- R6: A write of any value to 0xFB00 while the flag is set clears the flag and the length. Capture then begins again at offset 0 on the next falling edge of select.
- R7: The length saturates at 2048. Bytes beyond that are discarded, and the buffer does not wrap.
- R8: If reject is high during a capture, the rest of that frame is ignored and the flag stays 0. The receiver stays ready with length 0, and the next frame is captured normally.
- R9: Reads of other addresses, including 0xF800 and 0xFB01, return 0. Writes to any address other than 0xFB00 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sel_n | input | 1 | Serial link select, active low, marks one frame |
| spi_sck | input | 1 | Serial shift clock, data sampled on rising edge |
| spi_mosi | input | 1 | Serial data in |
| filt_reject | input | 1 | Destination-address reject from the filter |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_rdata | output | 8 | CPU read data, valid the cycle after cpu_rd |

## Verification
The serial inputs pass through two synchroniser stages and an edge detector. A stored byte and a raised flag therefore appear a few cycles after the shift clock or select edge that causes them. To cover that delay, the bench waits ten clocks after releasing select before it looks at any result. A CPU read is driven on a falling clock edge and sampled on the next falling edge, which matches the one-cycle read latency. The bench predicts the length, the flag and the buffer contents from the bytes it sends, and compares them at those sample points.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  typedef enum logic [1:0] {
    RX_ARMED,
    RX_CAPT,
    RX_DROP,
    RX_FULL
  } rx_state_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_BUF,
    RD_STAT,
    RD_LEN_LO,
    RD_LEN_HI
  } rd_sel_e;
endpackage

// File: rtl/rx_spi_deser.sv
module rx_spi_deser #(
  parameter int BITS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            sck,
  input  logic            mosi,
  output logic            sel_act,
  output logic            byte_vld,
  output logic [BITS-1:0] byte_q
);
  localparam int CW = $clog2(BITS);

  logic [2:0]      sync_q [SYNC_STAGES];
  logic            sck_prev;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BITS-1:0] sh_q, sh_d;
  logic            vld_q, vld_d;
  logic            sel_n_s, sck_s, mosi_s, rise;

  assign {sel_n_s, sck_s, mosi_s} = sync_q[SYNC_STAGES-1];
  assign sel_act  = ~sel_n_s;
  assign rise     = sck_s & ~sck_prev;
  assign byte_vld = vld_q;
  assign byte_q   = sh_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    if (!sel_act) begin
      cnt_d = '0;
    end else if (rise) begin
      sh_d  = {sh_q[BITS-2:0], mosi_s};
      vld_d = (cnt_q == CW'(BITS-1));
      cnt_d = vld_d ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b100;
      sck_prev <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      vld_q    <= 1'b0;
    end else begin
      sync_q[0] <= {sel_n, sck, mosi};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      sck_prev <= sck_s;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      vld_q    <= vld_d;
    end
  end
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import eth_rx_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_act,
  input  logic          byte_vld,
  input  logic          reject,
  input  logic          rearm,
  output logic          buf_we,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] len,
  output logic          rx_full,
  output logic          dropping,
  output logic          cap_own
);
  rx_state_e     st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          sel_prev;
  logic          room;

  assign room     = (cnt_q < LW'(DEPTH));
  assign buf_we   = (st_q == RX_CAPT) && byte_vld && !reject && room;
  assign wr_addr  = cnt_q[AW-1:0];
  assign len      = cnt_q;
  assign rx_full  = (st_q == RX_FULL);
  assign dropping = (st_q == RX_DROP);
  assign cap_own  = (st_q != RX_FULL);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      RX_ARMED: if (sel_act && !sel_prev) st_d = RX_CAPT;
      RX_CAPT: begin
        if (buf_we) cnt_d = cnt_q + 1'b1;
        if (reject)        st_d = RX_DROP;
        else if (!sel_act) st_d = RX_FULL;
      end
      RX_DROP: if (!sel_act) begin
        st_d  = RX_ARMED;
        cnt_d = '0;
      end
      RX_FULL: if (rearm) begin
        st_d  = RX_ARMED;
        cnt_d = '0;
      end
      default: st_d = RX_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_ARMED;
      cnt_q    <= '0;
      sel_prev <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      sel_prev <= sel_act;
    end
  end
endmodule

// File: rtl/rx_buf_ram.sv
module rx_buf_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/eth_rx_capture.sv
module eth_rx_capture
  import eth_rx_pkg::*;
#(
  parameter int          BUF_BYTES  = 2048,
  parameter logic [15:0] BUF_BASE   = 16'hF000,
  parameter logic [15:0] REG_STATUS = 16'hFB00,
  parameter logic [15:0] REG_LEN    = 16'hFB02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sel_n,
  input  logic        spi_sck,
  input  logic        spi_mosi,
  input  logic        filt_reject,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  output logic [7:0]  cpu_rdata
);
  localparam int BUF_AW = $clog2(BUF_BYTES);
  localparam int LEN_W  = BUF_AW + 1;
  localparam int DW     = 8;

  logic              sel_act, byte_vld, buf_we, rx_full, dropping, cap_own, rearm;
  logic [DW-1:0]     byte_q, ram_rdata;
  logic [BUF_AW-1:0] wr_addr, ram_addr;
  logic [LEN_W-1:0]  len;
  logic [15:0]       len16;
  logic              buf_hit;
  rd_sel_e           rd_sel_d, rd_sel_q;
  logic [DW-1:0]     reg_d, reg_q;

  rx_spi_deser #(.BITS(DW), .SYNC_STAGES(2)) u_deser (
    .clk(clk), .rst_n(rst_n), .sel_n(spi_sel_n), .sck(spi_sck), .mosi(spi_mosi),
    .sel_act(sel_act), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  rx_frame_ctl #(.DEPTH(BUF_BYTES), .AW(BUF_AW), .LW(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .byte_vld(byte_vld),
    .reject(filt_reject), .rearm(rearm), .buf_we(buf_we), .wr_addr(wr_addr),
    .len(len), .rx_full(rx_full), .dropping(dropping), .cap_own(cap_own)
  );

  assign ram_addr = cap_own ? wr_addr : cpu_addr[BUF_AW-1:0];

  rx_buf_ram #(.DEPTH(BUF_BYTES), .AW(BUF_AW), .DW(DW)) u_ram (
    .clk(clk), .we(buf_we), .addr(ram_addr), .wdata(byte_q), .rdata(ram_rdata)
  );

  assign rearm   = cpu_wr && (cpu_addr == REG_STATUS);
  assign buf_hit = (cpu_addr[15:BUF_AW] == BUF_BASE[15:BUF_AW]);
  assign len16   = 16'(len);

  always_comb begin
    rd_sel_d = RD_NONE;
    if (buf_hit)                          rd_sel_d = RD_BUF;
    else if (cpu_addr == REG_STATUS)      rd_sel_d = RD_STAT;
    else if (cpu_addr == REG_LEN)         rd_sel_d = RD_LEN_LO;
    else if (cpu_addr == REG_LEN + 16'd1) rd_sel_d = RD_LEN_HI;
    unique case (rd_sel_d)
      RD_STAT:   reg_d = {7'b0, rx_full};
      RD_LEN_LO: reg_d = len16[7:0];
      RD_LEN_HI: reg_d = len16[15:8];
      default:   reg_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel_q <= RD_NONE;
      reg_q    <= '0;
    end else if (cpu_rd) begin
      rd_sel_q <= rd_sel_d;
      reg_q    <= reg_d;
    end
  end

  assign cpu_rdata = (rd_sel_q == RD_BUF) ? ram_rdata : reg_q;
endmodule

// File: rtl/eth_rx_capture_chk.sv
module eth_rx_capture_chk #(
  parameter int DEPTH = 2048,
  parameter int LW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_full,
  input logic          buf_we,
  input logic          byte_vld,
  input logic          rearm,
  input logic          dropping,
  input logic [LW-1:0] len
);
  assert_len_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LW'(DEPTH));

  assert_full_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !buf_we);

  assert_len_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rearm |=> rx_full && $stable(len));

  assert_rearm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && rearm |=> !rx_full && (len == '0));

  assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |-> !buf_we && !rx_full);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  assert_write_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> len == $past(len) + 1'b1);
endmodule

bind eth_rx_capture eth_rx_capture_chk #(.DEPTH(BUF_BYTES), .LW(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .buf_we(buf_we),
  .byte_vld(byte_vld), .rearm(rearm), .dropping(dropping), .len(len)
);

// File: tb/test_eth_rx_capture.sv
`timescale 1ns/1ps
module test_eth_rx_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sel_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, filt_reject = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  eth_rx_capture i_eth_rx_capture (
    .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .filt_reject(filt_reject), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata)
  );

  // behavioural reference: expected buffer, length and flag
  logic [7:0] exp_mem [2048];
  int         exp_len = 0;
  bit         exp_full = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = b[i];
      repeat (2) @(negedge clk);
      spi_sck = 1'b1;
      repeat (2) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 7 + seed) ^ (i >= 2048 ? 8'hA5 : 8'h00));
  endfunction

  // frame of n bytes from pattern seed; reject after byte rej_at (-1 none); extra trailing bits
  task automatic frame(input int seed, input int n, input int rej_at, input int extra);
    bool_t: begin end
    @(negedge clk);
    spi_sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      send_bits(pat(seed, i), 8);
      if (i == rej_at) begin
        repeat (4) @(negedge clk);
        filt_reject = 1'b1;
      end
      if (!exp_full && (rej_at < 0 || i <= rej_at) && i < 2048) exp_mem[i] = pat(seed, i);
    end
    if (extra > 0) send_bits(8'hFF, extra);
    repeat (4) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (6) @(negedge clk);
    filt_reject = 1'b0;
    repeat (4) @(negedge clk);
    if (!exp_full) begin
      if (rej_at >= 0) exp_len = 0;
      else begin
        exp_len  = (n > 2048) ? 2048 : n;
        exp_full = 1;
      end
    end
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic cpu_write(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a == 16'hFB00 && exp_full) begin
      exp_full = 0;
      exp_len = 0;
    end
  endtask

  task automatic check_regs(input string req);
    cpu_read(16'hFB00, rd); check(req, rd, {7'b0, exp_full});
    cpu_read(16'hFB02, rd); check(req, rd, 8'(exp_len));
    cpu_read(16'hFB03, rd); check(req, rd, 8'(exp_len >> 8));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_regs("R1");

    // R2 R3 R5: five bytes plus three stray bits
    frame(16'hDE, 5, -1, 3);
    check_regs("R3");
    for (int i = 0; i < 5; i++) begin
      cpu_read(16'hF000 + 16'(i), rd);
      check("R2 R5", rd, exp_mem[i]);
    end

    // R4: traffic while full is ignored
    frame(16'h31, 3, -1, 0);
    check_regs("R4");
    cpu_read(16'hF000, rd); check("R4", rd, exp_mem[0]);

    // R9: unmapped reads and writes
    cpu_read(16'hFB01, rd); check("R9", rd, 8'h00);
    cpu_read(16'hF800, rd); check("R9", rd, 8'h00);
    cpu_write(16'hF000);
    cpu_write(16'hFB01);
    cpu_read(16'hF000, rd); check("R9", rd, exp_mem[0]);
    check_regs("R9");

    // R6: re-arm
    cpu_write(16'hFB00);
    check_regs("R6");

    // R8: rejected frame
    frame(16'h50, 6, 1, 0);
    check_regs("R8");
    frame(16'h11, 4, -1, 0);
    check_regs("R8");
    for (int i = 0; i < 4; i++) begin
      cpu_read(16'hF000 + 16'(i), rd);
      check("R8 R6", rd, exp_mem[i]);
    end

    // R7: oversize frame saturates
    cpu_write(16'hFB00);
    frame(16'h03, 2050, -1, 0);
    check_regs("R7");
    cpu_read(16'hF000, rd); check("R7", rd, exp_mem[0]);
    cpu_read(16'hF7FF, rd); check("R7", rd, exp_mem[2047]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule